// File: doc/BRIEF.md
# Performance Event Counter Unit

The unit keeps two programmable event counters with 64-bit values. Each cycle it receives a per-cycle occurrence count for each of a small set of event lanes. Each lane also carries an 8-bit attribute byte, and a current-privilege-mode bit comes in alongside. Each counter picks one lane by event number and qualifies it with a unit mask. It then applies a privilege filter and an optional threshold comparison, which can be inverted. Finally it adds one per qualifying cycle (duration mode) or one per rising edge of the qualifying condition (event mode).

Software works through a plain request port. Each request carries a valid bit, an operation code, a counter index and a 32-bit data word. The operations set up a configuration, read it back, start or stop a counter, clear it, or read its value. Every accepted request gets a one-cycle response pulse the cycle after it is presented. The response carries an error bit and 64 bits of data.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset both counters hold zero, are stopped, and return an all-zero configuration word.
- R2: The configuration word has the event number in bits 7:0, the unit mask in bits 15:8, the flag byte in bits 23:16 and the threshold in bits 31:24. Operation 0 writes it and operation 1 returns it unchanged in the low 32 bits of the response data.
- R3: A request whose counter index is 2 or more gets a response with the error bit set and changes no counter.
- R4: Flag bit 0 enables counting while the privilege input is 1 (user mode), and flag bit 1 enables counting while it is 0 (kernel mode). With both bits clear a counter never advances.
- R5: With flag bit 2 clear (duration mode), a running counter adds one on every cycle whose condition holds.
- R6: With flag bit 2 set (event mode), a running counter adds one only on a cycle whose condition holds after a cycle in which it did not.
- R7: With a zero threshold, the condition is that the selected per-cycle count is non-zero, and flag bit 3 is ignored. With a non-zero threshold the condition is count >= threshold, or count < threshold when flag bit 3 is set.
- R8: The event number picks the lane. An event number of 8 or more yields a zero count. A non-zero unit mask yields a zero count unless the lane's attribute byte shares a set bit with it.
- R9: A configuration write clears that counter's value. Operation 4 clears it as well. A clear in the same cycle as a qualifying increment leaves the value at zero.
- R10: Operation 5 returns the counter's 64-bit value, as it stood in the request cycle, in the next cycle's response.
- R11: Operation 2 starts and operation 3 stops the indexed counter only. Counter 1 advances only while counter 0 is also running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0 setup, 1 get config, 2 start, 3 stop, 4 clear, 5 read) |
| req_idx | input | 2 | Counter index |
| req_wdata | input | 32 | Configuration word for setup |
| rsp_valid | output | 1 | Response pulse, one cycle after a request |
| rsp_err | output | 1 | Bad index or bad operation code |
| rsp_data | output | 64 | Configuration word or counter value |
| evt_counts | input | 32 | Eight 4-bit per-cycle event counts, lane k at bits 4k+3:4k |
| evt_units | input | 64 | Eight attribute bytes, lane k at bits 8k+7:8k |
| priv_user | input | 1 | 1 for user mode, 0 for kernel mode |

## Verification
One stepped count pattern repeats values from 0 to 6 with zeros mixed in. It is swept over five thresholds, both invert settings and both counting modes. The sweep separates the >= test from the < test, edge counting from level counting, and the zero-threshold rule from a threshold of one. A pattern that alternates privilege separates the two privilege enables from each other and from the case with both disabled. Activity on a lane other than the selected one, an out-of-range event number, and matching and non-matching unit masks show that only the chosen, qualified lane is counted. Separate sequences cover a clear coinciding with an increment, and counter 1 running while counter 0 is stopped.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef struct packed {
        logic [7:0] thr;
        logic [7:0] flags;
        logic [7:0] umask;
        logic [7:0] evsel;
    } pcu_cfg_t;

    typedef enum logic [2:0] {
        OP_SETUP  = 3'd0,
        OP_GETCFG = 3'd1,
        OP_START  = 3'd2,
        OP_STOP   = 3'd3,
        OP_CLEAR  = 3'd4,
        OP_READ   = 3'd5
    } pcu_op_e;

    localparam int FL_USR = 0;
    localparam int FL_OS  = 1;
    localparam int FL_EDG = 2;
    localparam int FL_INV = 3;

endpackage

// File: rtl/pcu_event_pick.sv
module pcu_event_pick #(
    parameter int NUM_EVT = 8,
    parameter int EVT_CW  = 4
) (
    input  logic [NUM_EVT*EVT_CW-1:0] evt_counts,
    input  logic [NUM_EVT*8-1:0]      evt_units,
    input  logic [7:0]                evsel,
    input  logic [7:0]                umask,
    output logic [EVT_CW-1:0]         sel_cnt
);
    logic [EVT_CW-1:0] lane_cnt;
    logic [7:0]        lane_unit;
    logic              unit_ok;

    always_comb begin
        lane_cnt  = '0;
        lane_unit = '0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (evsel == 8'(k)) begin
                lane_cnt  = evt_counts[k*EVT_CW +: EVT_CW];
                lane_unit = evt_units[k*8 +: 8];
            end
        end
        unit_ok = (umask == 8'd0) || ((lane_unit & umask) != 8'd0);
        sel_cnt = unit_ok ? lane_cnt : '0;
    end
endmodule

// File: rtl/pcu_qualify.sv
module pcu_qualify #(
    parameter int EVT_CW = 4
) (
    input  logic [EVT_CW-1:0] sel_cnt,
    input  logic [7:0]        thr,
    input  logic [3:0]        flags,
    input  logic              priv_user,
    output logic              cond
);
    import pcu_pkg::*;

    logic [7:0] cnt8;
    logic       priv_ok;
    logic       level;

    always_comb begin
        cnt8    = 8'(sel_cnt);
        priv_ok = priv_user ? flags[FL_USR] : flags[FL_OS];
        if (thr == 8'd0)
            level = (cnt8 != 8'd0);
        else if (flags[FL_INV])
            level = (cnt8 < thr);
        else
            level = (cnt8 >= thr);
        cond = priv_ok && level;
    end
endmodule

// File: rtl/pcu_counter_slice.sv
module pcu_counter_slice #(
    parameter int CNT_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  pcu_pkg::pcu_cfg_t    cfg_in,
    input  logic                 clr,
    input  logic                 start,
    input  logic                 stop,
    input  logic                 allow,
    input  logic                 cond,
    output pcu_pkg::pcu_cfg_t    cfg_q,
    output logic                 run_q,
    output logic [CNT_W-1:0]     value_q
);
    import pcu_pkg::*;

    typedef struct packed {
        pcu_cfg_t         cfg;
        logic             run;
        logic             prev;
        logic [CNT_W-1:0] value;
    } slice_st_t;

    slice_st_t st_d, st_q;
    logic      inc;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = cfg_in;
        if (start)  st_d.run = 1'b1;
        if (stop)   st_d.run = 1'b0;
        st_d.prev = cond;
        inc = st_q.run && allow &&
              (st_q.cfg.flags[FL_EDG] ? (cond && !st_q.prev) : cond);
        if (clr)
            st_d.value = '0;
        else if (inc)
            st_d.value = st_q.value + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_q   = st_q.cfg;
    assign run_q   = st_q.run;
    assign value_q = st_q.value;

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value_q == '0));

    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (value_q == $past(value_q) || value_q == $past(value_q) + CNT_W'(1)));

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !clr) |=> $stable(value_q));

    // R4
    no_priv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_q.flags[FL_USR] && !cfg_q.flags[FL_OS] && !clr) |=> $stable(value_q));

    // R6
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.flags[FL_EDG] && !clr && !cfg_we && $past(cond) && cond) |=> $stable(value_q));
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
    parameter int NUM_CTR = 2,
    parameter int IDX_W   = 2,
    parameter int NUM_EVT = 8,
    parameter int EVT_CW  = 4,
    parameter int CNT_W   = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [2:0]                req_op,
    input  logic [IDX_W-1:0]          req_idx,
    input  logic [31:0]               req_wdata,
    output logic                      rsp_valid,
    output logic                      rsp_err,
    output logic [CNT_W-1:0]          rsp_data,
    input  logic [NUM_EVT*EVT_CW-1:0] evt_counts,
    input  logic [NUM_EVT*8-1:0]      evt_units,
    input  logic                      priv_user
);
    import pcu_pkg::*;

    typedef struct packed {
        logic             valid;
        logic             err;
        logic [CNT_W-1:0] data;
    } rsp_st_t;

    rsp_st_t rsp_d, rsp_q;

    logic [NUM_CTR-1:0] sel_hot, cfg_we, clr, start, stop, run, allow, cond;
    logic [CNT_W-1:0]   val_arr [NUM_CTR];
    pcu_cfg_t           cfg_arr [NUM_CTR];
    logic               idx_ok, op_ok;

    always_comb begin
        sel_hot = '0;
        for (int k = 0; k < NUM_CTR; k++)
            sel_hot[k] = (req_idx == IDX_W'(k));
        idx_ok = (sel_hot != '0);
        op_ok  = (req_op <= 3'(OP_READ));
        for (int k = 0; k < NUM_CTR; k++) begin
            cfg_we[k] = req_valid && sel_hot[k] && (req_op == OP_SETUP);
            start[k]  = req_valid && sel_hot[k] && (req_op == OP_START);
            stop[k]   = req_valid && sel_hot[k] && (req_op == OP_STOP);
            clr[k]    = cfg_we[k] || (req_valid && sel_hot[k] && (req_op == OP_CLEAR));
        end
    end

    generate
        for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
            logic [EVT_CW-1:0] sel_cnt;

            if (g == 0) begin : g_head
                assign allow[g] = 1'b1;
            end else begin : g_link
                assign allow[g] = allow[g-1] && run[g-1];
            end

            pcu_event_pick #(.NUM_EVT(NUM_EVT), .EVT_CW(EVT_CW)) u_pick (
                .evt_counts (evt_counts),
                .evt_units  (evt_units),
                .evsel      (cfg_arr[g].evsel),
                .umask      (cfg_arr[g].umask),
                .sel_cnt    (sel_cnt)
            );

            pcu_qualify #(.EVT_CW(EVT_CW)) u_qual (
                .sel_cnt    (sel_cnt),
                .thr        (cfg_arr[g].thr),
                .flags      (cfg_arr[g].flags[3:0]),
                .priv_user  (priv_user),
                .cond       (cond[g])
            );

            pcu_counter_slice #(.CNT_W(CNT_W)) u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg_we  (cfg_we[g]),
                .cfg_in  (pcu_cfg_t'(req_wdata)),
                .clr     (clr[g]),
                .start   (start[g]),
                .stop    (stop[g]),
                .allow   (allow[g]),
                .cond    (cond[g]),
                .cfg_q   (cfg_arr[g]),
                .run_q   (run[g]),
                .value_q (val_arr[g])
            );

            if (g > 0) begin : g_chain_chk
                // R11
                chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (!run[g-1] && !clr[g]) |=> $stable(val_arr[g]));
            end
        end
    endgenerate

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !(idx_ok && op_ok);
        if (req_valid && idx_ok) begin
            for (int k = 0; k < NUM_CTR; k++) begin
                if (sel_hot[k]) begin
                    if (req_op == OP_GETCFG) rsp_d.data = CNT_W'(cfg_arr[k]);
                    if (req_op == OP_READ)   rsp_d.data = val_arr[k];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_data  = rsp_q.data;

    // R3
    bad_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_idx >= IDX_W'(NUM_CTR)) |=> (rsp_valid && rsp_err));

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/sim_perf_counter_unit.sv
module sim_perf_counter_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_idx = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_data;
    logic [31:0] evt_counts = '0;
    logic [63:0] evt_units = '0;
    logic        priv_user = 1'b1;

    int checks = 0;
    int errors = 0;
    logic        got_v, got_e;
    logic [63:0] got_d;

    int pat_cnt [32];
    bit pat_usr [32];

    always #2 clk = ~clk;

    perf_counter_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_idx(req_idx), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_data(rsp_data), .evt_counts(evt_counts),
        .evt_units(evt_units), .priv_user(priv_user)
    );

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [31:0] mk(input logic [7:0] thr, input logic [7:0] fl,
                                       input logic [7:0] um, input logic [7:0] ev);
        return {thr, fl, um, ev};
    endfunction

    function automatic bit cond_m(input logic [31:0] cfg, input int cnt, input bit usr);
        bit pok, lvl;
        int thr;
        thr = int'(cfg[31:24]);
        pok = usr ? cfg[16] : cfg[17];
        if (thr == 0)      lvl = (cnt != 0);
        else if (cfg[19])  lvl = (cnt < thr);
        else               lvl = (cnt >= thr);
        return pok && lvl;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_lane(input int lane, input int cnt);
        evt_counts = '0;
        evt_counts[lane*4 +: 4] = 4'(cnt);
    endtask

    // Inputs are set after a negedge; the response is taken one negedge later.
    task automatic do_req(input logic [2:0] op, input int idx, input logic [31:0] wd);
        req_valid = 1'b1; req_op = op; req_idx = 2'(idx); req_wdata = wd;
        @(negedge clk);
        got_v = rsp_valid; got_e = rsp_err; got_d = rsp_data;
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        set_lane(3, 0); priv_user = 1'b1;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Runs pattern on driven lane; live=0 means the counter must see nothing.
    task automatic run_pattern(input string req, input int ctr, input logic [31:0] cfg,
                               input int lane, input int n, input bit live);
        bit prev, c;
        longint exp;
        do_req(3'd0, ctr, cfg);
        idle(1);
        do_req(3'd2, ctr, 0);
        exp = 0;
        prev = live ? cond_m(cfg, 0, 1'b1) : cond_m(cfg, 0, 1'b1);
        for (int i = 0; i <= n; i++) begin
            int cv; bit uv;
            cv = (i < n) ? pat_cnt[i] : 0;
            uv = (i < n) ? pat_usr[i] : 1'b1;
            c = cond_m(cfg, live ? cv : 0, uv);
            if (cfg[18] ? (c && !prev) : c) exp++;
            prev = c;
            set_lane(lane, cv); priv_user = uv;
            if (i < n) @(negedge clk);
            else do_req(3'd3, ctr, 0);
        end
        idle(1);
        do_req(3'd5, ctr, 0);
        check(req, got_d, 64'(exp));
    endtask

    initial begin
        int thrs [5] = '{0, 1, 3, 6, 7};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int k = 0; k < 2; k++) begin
            do_req(3'd5, k, 0);
            check("R1 value", got_d, 64'd0);
            do_req(3'd1, k, 0);
            check("R1 config", got_d, 64'd0);
        end

        // R2 readback
        do_req(3'd0, 1, mk(8'hA5, 8'hF3, 8'h5C, 8'h3E));
        do_req(3'd1, 1, 0);
        check("R2 readback", got_d, {32'd0, mk(8'hA5, 8'hF3, 8'h5C, 8'h3E)});
        check("R10 response pulse", {63'd0, got_v}, 64'd1);

        // R3 bad index
        do_req(3'd0, 2, mk(8'h11, 8'h11, 8'h11, 8'h11));
        check("R3 error flag", {63'd0, got_e}, 64'd1);
        do_req(3'd1, 1, 0);
        check("R3 no change", got_d, {32'd0, mk(8'hA5, 8'hF3, 8'h5C, 8'h3E)});
        do_req(3'd1, 3, 0);
        check("R3 error idx3", {63'd0, got_e}, 64'd1);

        for (int i = 0; i < 32; i++) begin
            pat_cnt[i] = (i * 5 + 3) % 7;
            pat_usr[i] = 1'b1;
        end
        // R5 R6 R7 sweep over threshold, invert and mode
        for (int t = 0; t < 5; t++)
            for (int inv = 0; inv < 2; inv++)
                for (int e = 0; e < 2; e++)
                    run_pattern($sformatf("R7 thr%0d inv%0d %s", thrs[t], inv,
                                          e ? "R6 edge" : "R5 dur"), 0,
                                mk(8'(thrs[t]), 8'(3 | (e << 2) | (inv << 3)), 8'h00, 8'd3),
                                3, 20, 1'b1);

        // R4 privilege gating
        for (int i = 0; i < 32; i++) pat_usr[i] = (i % 3 != 0);
        run_pattern("R4 user only", 0, mk(0, 8'h01, 0, 3), 3, 20, 1'b1);
        run_pattern("R4 kernel only", 0, mk(0, 8'h02, 0, 3), 3, 20, 1'b1);
        run_pattern("R4 none", 0, mk(0, 8'h00, 0, 3), 3, 20, 1'b1);
        run_pattern("R4 edge user", 0, mk(0, 8'h05, 0, 3), 3, 20, 1'b1);
        for (int i = 0; i < 32; i++) pat_usr[i] = 1'b1;

        // R8 lane and unit mask
        evt_units = '0;
        evt_units[3*8 +: 8] = 8'h0C;
        run_pattern("R8 other lane", 0, mk(0, 8'h03, 0, 5), 3, 20, 1'b0);
        run_pattern("R8 lane 5", 0, mk(0, 8'h03, 0, 5), 5, 20, 1'b1);
        run_pattern("R8 evsel out of range", 0, mk(0, 8'h03, 0, 9), 3, 20, 1'b0);
        run_pattern("R8 umask match", 0, mk(0, 8'h03, 8'h04, 3), 3, 20, 1'b1);
        run_pattern("R8 umask miss", 0, mk(0, 8'h03, 8'h30, 3), 3, 20, 1'b0);
        evt_units = '0;

        // R9 clear beats increment, clear command, setup clears
        do_req(3'd0, 0, mk(0, 8'h03, 0, 3));
        do_req(3'd2, 0, 0);
        set_lane(3, 2);
        repeat (4) @(negedge clk);
        do_req(3'd5, 0, 0);
        check("R10 live read", got_d, 64'd4);
        do_req(3'd4, 0, 0);
        set_lane(3, 0);
        do_req(3'd3, 0, 0);
        do_req(3'd5, 0, 0);
        check("R9 clear beats increment", got_d, 64'd0);
        do_req(3'd2, 0, 0);
        set_lane(3, 1);
        repeat (3) @(negedge clk);
        set_lane(3, 0);
        do_req(3'd3, 0, 0);
        do_req(3'd5, 0, 0);
        check("R9 count before setup", got_d, 64'd3);
        do_req(3'd0, 0, mk(0, 8'h03, 0, 3));
        do_req(3'd5, 0, 0);
        check("R9 setup clears", got_d, 64'd0);

        // R11 counter 1 needs counter 0 running
        do_req(3'd0, 1, mk(0, 8'h03, 0, 3));
        do_req(3'd2, 1, 0);
        set_lane(3, 2);
        repeat (5) @(negedge clk);
        set_lane(3, 0);
        do_req(3'd3, 1, 0);
        do_req(3'd5, 1, 0);
        check("R11 counter1 frozen", got_d, 64'd0);
        do_req(3'd2, 1, 0);
        do_req(3'd2, 0, 0);
        set_lane(3, 2);
        repeat (5) @(negedge clk);
        set_lane(3, 0);
        do_req(3'd3, 0, 0);
        set_lane(3, 2);
        repeat (2) @(negedge clk);
        set_lane(3, 0);
        do_req(3'd5, 1, 0);
        check("R11 counter1 chained", got_d, 64'd5);
        do_req(3'd5, 0, 0);
        check("R11 counter0", got_d, 64'd5);
        do_req(3'd3, 1, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule